// File: doc/BRIEF.md
# Single-Vector Interrupt Entry Sequencer

This block handles interrupts for a small 16-bit processor that has only one handler. It owns a control word. Bit 0 of that word is the global interrupt enable. The block also keeps a pending latch that software cannot see. An incoming request is always captured in the pending latch first. The interrupt is taken at an instruction boundary, and only while the enable bit is set. Because of this, a request that arrives while interrupts are off waits in the latch. It fires as soon as software turns the enable bit back on.

Taking an interrupt runs a fixed three-step entry:
1. Read the handler address from a fixed memory word.
2. Push the address of the next unexecuted instruction onto the stack. The push predecrements SP.
3. Load PC with the handler address.

The same edge that starts the entry clears both the enable bit and the pending latch. The handler must set the enable bit again before it returns. The return itself is an ordinary POP PC.

While the entry is running, `busy` holds instruction fetch. The memory port assumes a synchronous RAM with one cycle of read latency.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `cr_rd` is 0, `busy` is 0, and `mem_req`, `sp_load` and `pc_load` are all 0.
- R2: A write with `cr_wr_en` stores bit 0 of `cr_wr_data` as the enable bit. `cr_rd[0]` shows the enable bit, and `cr_rd[15:1]` always reads 0.
- R3: A request (`irq_req` high for one cycle) while the enable bit is 0 starts no entry. `busy` stays 0.
- R4: If a request is pending and software writes enable = 1, the entry starts on the next clock edge at which `at_boundary` is 1. With `at_boundary` held high, `busy` rises one cycle after the write edge.
- R5: An entry starts only on an edge where `at_boundary` is 1. A pending request waits while `at_boundary` is 0.
- R6: The edge that starts the entry clears the enable bit, so `cr_rd[0]` is 0 while `busy` is high. If a control write lands on that same edge, the clear wins.
- R7: In the first entry cycle, the block issues a memory read (`mem_req`=1, `mem_we`=0) at address `VEC_ADDR`. The default is 0xFFFE.
- R8: In the second entry cycle, the block writes `pc_in` (sampled when the entry started) to address SP-1. Here SP is the `sp_in` value sampled at the same time. In that cycle `sp_load`=1 with `sp_val`=SP-1.
- R9: In the third entry cycle, `pc_load`=1 and `pc_val` equals the word read from `VEC_ADDR`. `busy` is 0 in the following cycle.
- R10: An entry clears the pending latch, so one request causes exactly one entry. A request that arrives during an entry is latched. It is taken after the enable bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request, one pulse per request |
| at_boundary | input | 1 | High when the core is between instructions |
| cr_wr_en | input | 1 | Control word write strobe |
| cr_wr_data | input | 16 | Control word write data (bit 0 = enable) |
| cr_rd | output | 16 | Control word read value |
| pc_in | input | 16 | Address of the next unexecuted instruction |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Entry sequence in progress; fetch stalled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after a read request |
| sp_load | output | 1 | Load SP from `sp_val` |
| sp_val | output | 16 | New stack pointer |
| pc_load | output | 1 | Load PC from `pc_val` |
| pc_val | output | 16 | Handler address |

## Verification
The bench targets the following corner cases:
- **Request while disabled.** A design that ignored the pending latch would never take this request. One that bypassed the enable bit would jump at once.
- **Request that waits for an instruction boundary.** A design that ignored `at_boundary` would enter in the middle of an instruction.
- **Control write on the same edge as entry start.** If the write won, the handler would start with interrupts still enabled.
- **Re-enable after an entry.** A design that left the pending latch set would take the same request twice.
- **Request that arrives during an entry.** A design that dropped it would lose the interrupt.

The bench also checks the push address and the handler data in their exact cycles. An off-by-one SP or a stale read would show up there.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_PUSH  = 2'd2,
    ST_LOAD  = 2'd3
  } entry_st_t;
endpackage

// File: rtl/irq_gate.sv
// Enable bit, hidden pending latch and the take decision.
module irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic at_boundary,
  input  logic seq_idle,
  input  logic cr_wr_en,
  input  logic cr_wr_bit,
  output logic irq_en,
  output logic take
);
  logic pend_q;
  logic en_q;

  assign take   = at_boundary & seq_idle & en_q & pend_q;
  assign irq_en = en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // Entry clears enable; it overrides a coincident software write.
      if (take)          en_q <= 1'b0;
      else if (cr_wr_en) en_q <= cr_wr_bit;
      // A request arriving on the take edge survives as a new pending one.
      if (take)         pend_q <= irq_req;
      else if (irq_req) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/entry_seq.sv
// Three-step entry: vector read, PC push, PC load. All outputs registered.
module entry_seq
  import irq_entry_pkg::*;
#(
  parameter int               WORD_W   = 16,
  parameter logic [WORD_W-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [WORD_W-1:0] pc_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              idle,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              sp_load,
  output logic [WORD_W-1:0] sp_val,
  output logic              pc_load,
  output logic [WORD_W-1:0] pc_val
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  entry_st_t         st_q;
  logic [WORD_W-1:0] pc_sav_q;
  logic [WORD_W-1:0] sp_sav_q;

  assign idle = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      pc_sav_q  <= '0;
      sp_sav_q  <= '0;
      busy      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      sp_load   <= 1'b0;
      sp_val    <= '0;
      pc_load   <= 1'b0;
      pc_val    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            st_q     <= ST_FETCH;
            pc_sav_q <= pc_in;
            sp_sav_q <= sp_in;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= VEC_ADDR;
          end
        end
        ST_FETCH: begin
          st_q      <= ST_PUSH;
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= sp_sav_q - ONE;
          mem_wdata <= pc_sav_q;
          sp_load   <= 1'b1;
          sp_val    <= sp_sav_q - ONE;
        end
        ST_PUSH: begin
          st_q    <= ST_LOAD;
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          sp_load <= 1'b0;
          pc_load <= 1'b1;
          pc_val  <= mem_rdata;
        end
        default: begin
          st_q    <= ST_IDLE;
          pc_load <= 1'b0;
          busy    <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int               WORD_W   = 16,
  parameter logic [WORD_W-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req,
  input  logic              at_boundary,
  input  logic              cr_wr_en,
  input  logic [WORD_W-1:0] cr_wr_data,
  output logic [WORD_W-1:0] cr_rd,
  input  logic [WORD_W-1:0] pc_in,
  input  logic [WORD_W-1:0] sp_in,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              sp_load,
  output logic [WORD_W-1:0] sp_val,
  output logic              pc_load,
  output logic [WORD_W-1:0] pc_val
);
  logic take;
  logic seq_idle;
  logic irq_en;

  irq_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .at_boundary(at_boundary),
    .seq_idle   (seq_idle),
    .cr_wr_en   (cr_wr_en),
    .cr_wr_bit  (cr_wr_data[0]),
    .irq_en     (irq_en),
    .take       (take)
  );

  entry_seq #(.WORD_W(WORD_W), .VEC_ADDR(VEC_ADDR)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .pc_in    (pc_in),
    .sp_in    (sp_in),
    .mem_rdata(mem_rdata),
    .idle     (seq_idle),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .sp_load  (sp_load),
    .sp_val   (sp_val),
    .pc_load  (pc_load),
    .pc_val   (pc_val)
  );

  // Reserved control bits read as zero.
  assign cr_rd = {{(WORD_W-1){1'b0}}, irq_en};
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int               WORD_W   = 16,
  parameter logic [WORD_W-1:0] VEC_ADDR = 16'hFFFE
) (
  input logic              clk,
  input logic              rst,
  input logic              at_boundary,
  input logic [WORD_W-1:0] cr_rd,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic              pc_load
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    cr_rd[WORD_W-1:1] == '0);

  assert_no_entry_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (!cr_rd[0] && !busy) |=> !busy);

  assert_boundary_only_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(at_boundary));

  assert_enable_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cr_rd[0]);

  assert_vector_read_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (mem_req && !mem_we && mem_addr == VEC_ADDR));

  assert_push_follows_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> (mem_req && mem_we));

  assert_load_ends_R9: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !busy);
endmodule

bind irq_entry_seq irq_entry_chk #(.WORD_W(WORD_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .at_boundary(at_boundary),
  .cr_rd      (cr_rd),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .pc_load    (pc_load)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
  localparam logic [15:0] VEC  = 16'hFFFE;
  localparam logic [15:0] HNDL = 16'h4A20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0, at_boundary = 1'b1, cr_wr_en = 1'b0;
  logic [15:0] cr_wr_data = '0, pc_in = '0, sp_in = '0, mem_rdata;
  logic [15:0] cr_rd, mem_addr, mem_wdata, sp_val, pc_val;
  logic        busy, mem_req, mem_we, sp_load, pc_load;
  logic [15:0] wr_addr_seen = '0, wr_data_seen = '0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_entry_seq #(.WORD_W(16), .VEC_ADDR(VEC)) i_irq_entry_seq (.*);

  // Synchronous memory model: only the vector word holds data.
  always_ff @(posedge clk) begin
    mem_rdata <= (mem_req && !mem_we && mem_addr == VEC) ? HNDL : 16'h0000;
    if (mem_req && mem_we) begin
      wr_addr_seen <= mem_addr;
      wr_data_seen <= mem_wdata;
    end
  end

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cr_write(input logic [15:0] d);
    cr_wr_en = 1'b1; cr_wr_data = d;
    step();
    cr_wr_en = 1'b0;
  endtask

  task automatic pulse_irq();
    irq_req = 1'b1;
    step();
    irq_req = 1'b0;
  endtask

  // Check the three entry cycles; called right after the edge that started the entry.
  task automatic chk_entry(input logic [15:0] pc, input logic [15:0] sp);
    chk("R6 busy+enable clear", {busy, cr_rd[14:0]}, 16'h8000);
    chk("R7 vector read", {mem_req, mem_we, 14'h0}, 16'h8000);
    chk("R7 vector addr", mem_addr, VEC);
    step();
    chk("R8 push write", {mem_req, mem_we, sp_load, 13'h0}, 16'hE000);
    chk("R8 push addr", mem_addr, sp - 16'd1);
    chk("R8 push data", mem_wdata, pc);
    chk("R8 sp value", sp_val, sp - 16'd1);
    step();
    chk("R9 pc_load", {pc_load, busy, 14'h0}, 16'hC000);
    chk("R9 handler", pc_val, HNDL);
    chk("R8 mem saw write", wr_addr_seen, sp - 16'd1);
    step();
    chk("R9 busy falls", {busy, pc_load, 14'h0}, 16'h0000);
  endtask

  // Stimulus table for control word writes: {write data, expected read}.
  localparam logic [31:0] CR_TBL [8] = '{
    {16'hFFFF, 16'h0001}, {16'hFFFE, 16'h0000}, {16'h0001, 16'h0001},
    {16'h8000, 16'h0000}, {16'h0003, 16'h0001}, {16'hAAAA, 16'h0000},
    {16'h5555, 16'h0001}, {16'h0000, 16'h0000}
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 cr_rd", cr_rd, 16'h0000);
    chk("R1 outputs", {busy, mem_req, sp_load, pc_load, 12'h0}, 16'h0000);

    // R2 table walk
    foreach (CR_TBL[i]) begin
      cr_write(CR_TBL[i][31:16]);
      chk("R2 cr readback", cr_rd, CR_TBL[i][15:0]);
    end

    // R3 request while disabled
    pc_in = 16'h1234; sp_in = 16'h8000;
    pulse_irq();
    for (int k = 0; k < 5; k++) chk("R3 no entry", {15'h0, busy}, 16'h0000);
    for (int k = 0; k < 5; k++) step();
    chk("R3 still idle", {15'h0, busy}, 16'h0000);

    // R4 enable with pending: busy rises one cycle after the write edge
    cr_write(16'h0001);
    chk("R4 not yet", {15'h0, busy}, 16'h0000);
    step();
    chk_entry(16'h1234, 16'h8000);

    // R10 no second entry after re-enable
    cr_write(16'h0001);
    for (int k = 0; k < 4; k++) step();
    chk("R10 single entry", {15'h0, busy}, 16'h0000);

    // R5 pending waits for a boundary
    at_boundary = 1'b0;
    pc_in = 16'h0200; sp_in = 16'h7000;
    pulse_irq();
    for (int k = 0; k < 4; k++) step();
    chk("R5 waits off-boundary", {15'h0, busy}, 16'h0000);
    at_boundary = 1'b1;
    step();
    chk_entry(16'h0200, 16'h7000);

    // R10 request during an entry is latched and taken after re-enable
    cr_write(16'h0001);
    pulse_irq();
    step();
    chk("R10 entry started", {15'h0, busy}, 16'h0001);
    pulse_irq();
    step(); step(); step();
    chk("R10 idle, disabled", {busy, cr_rd[14:0]}, 16'h0000);
    cr_write(16'h0001);
    step();
    chk("R10 latched request taken", {15'h0, busy}, 16'h0001);
    step(); step(); step();

    // R6 control write on the take edge loses to the clear
    at_boundary = 1'b0;
    cr_write(16'h0001);
    pulse_irq();
    at_boundary = 1'b1; cr_wr_en = 1'b1; cr_wr_data = 16'h0001;
    step();
    cr_wr_en = 1'b0;
    chk("R6 clear wins", {busy, cr_rd[14:0]}, 16'h8000);
    step(); step(); step();
    chk("R6 stays disabled", cr_rd, 16'h0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule